// File: doc/BRIEF.md
# Multicast hash address filter

This block makes the accept or drop decision for the destination address of a received Ethernet frame. The six address bytes arrive one per clock on a byte stream. The block runs a reflected CRC-32 over them, uses the low eight bits of that remainder to pick one bit of a 256-bit hash table, and combines the picked bit with a station-address comparison and two mode controls (promiscuous and all-multicast). One clock after the sixth byte it raises a single-cycle decision strobe together with the accept flag.

The host keeps the hash table up to date in three ways. It can write whole 16-bit words. It can feed an address into a second byte stream, which hashes the address and sets or clears its table bit. It can pulse a rebuild, which empties the table and leaves only the broadcast address bit set. The station address is loaded one byte at a time through a byte-select port. Any table word can be read back combinationally.

Top module: `mhf_addr_filter`

## Requirements
- R1: The hash is a CRC-32 with the reflected polynomial 0xEDB88320 and a starting value of all ones. There is no final inversion. The address bytes are taken first to last, and each byte is taken least significant bit first. The remainder bits [7:4] pick the table word and bits [3:0] pick the bit within that word. A group address (bit 0 of the first byte set) is accepted exactly when that table bit is set.
- R2: A destination byte is taken on every clock with `da_valid` high. The first byte is the most significant byte of the address as the bench writes it. Idle cycles may fall between bytes. `dec_valid` is high for exactly one clock: the clock after the edge that takes the sixth byte. `dec_accept` is low whenever `dec_valid` is low.
- R3: A write with `tbl_wr_en` high stores `tbl_wr_data` into the word at `tbl_wr_idx`. `tbl_rd_data` shows the word at `tbl_rd_idx` combinationally.
- R4: The host hash port takes six bytes on `hp_valid`. It samples `hp_set` together with the sixth byte. One clock after that byte the selected bit is written: to 1 when `hp_set` is high, to 0 when it is low. No other bit changes.
- R5: A `rebuild` pulse clears the whole table and then sets only the bit of the broadcast address FF:FF:FF:FF:FF:FF. Reset leaves the table in this same state and clears the station address to zero.
- R6: While `all_multi` is high, every word reads 0xFFFF and every group address is accepted. The stored table is not changed, and it reads back as before once `all_multi` drops.
- R7: A unicast address (bit 0 of the first byte clear) is accepted only if all six bytes equal the station address. Station byte select 0 addresses the first address byte and select 5 the last.
- R8: With `promisc` high, every address is accepted, whatever the table and the station address hold.
- R9: A station write with a byte select of 6 or 7 has no effect.
- R10: When `rebuild` and a word write occur in the same clock, the rebuild wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| promisc | input | 1 | Accept every address |
| all_multi | input | 1 | Treat every table bit as set |
| rebuild | input | 1 | Clear table and preload the broadcast bit |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_idx | input | 4 | Table word written |
| tbl_wr_data | input | 16 | Table word write data |
| tbl_rd_idx | input | 4 | Table word read back |
| tbl_rd_data | output | 16 | Table word read data |
| sta_wr_en | input | 1 | Station byte write strobe |
| sta_wr_sel | input | 3 | Station byte select, 0 = first byte |
| sta_wr_byte | input | 8 | Station byte value |
| hp_valid | input | 1 | Host hash port byte valid |
| hp_byte | input | 8 | Host hash port address byte |
| hp_set | input | 1 | 1 sets, 0 clears the hashed bit (sampled with sixth byte) |
| da_valid | input | 1 | Destination address byte valid |
| da_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Accept flag, valid with the strobe |

## Verification
Random group addresses are checked against two complementary table patterns. A bug in the CRC or the word and bit selection therefore shows up on both polarities, and a stuck accept cannot pass. The host hash port is driven with random addresses in set and clear passes, and the whole table is compared with a model after each operation. This exposes stray bits, wrong indices and the wrong sense of `hp_set`. The station address and six single-byte corruptions of it check every byte lane of the unicast compare. Broadcast, all-multicast and promiscuous cases are run against a table bit that is known to be clear, so that each mode override is seen to act on its own. Byte gaps separate the counting of valid bytes from the counting of clocks.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int WSEL_W     = 4;
    localparam int BSEL_W     = 4;
    localparam int TBL_WORDS  = 1 << WSEL_W;
    localparam int WORD_W     = 1 << BSEL_W;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    typedef logic [7:0]  octet_t;
    typedef logic [31:0] crc_t;

    typedef struct packed {
        logic [WSEL_W-1:0] word;
        logic [BSEL_W-1:0] bitsel;
    } tbl_idx_t;

    // one byte of a reflected CRC, LSB first
    function automatic crc_t crc_step(input crc_t cur, input octet_t data, input crc_t poly);
        crc_t c;
        c = cur ^ {24'h0, data};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
        end
        return c;
    endfunction

    // table index of the all-ones broadcast address
    function automatic tbl_idx_t bcast_index(input crc_t poly, input int nbytes);
        crc_t c;
        c = '1;
        for (int k = 0; k < nbytes; k++) begin
            c = crc_step(c, 8'hFF, poly);
        end
        return tbl_idx_t'(c[WSEL_W+BSEL_W-1:0]);
    endfunction

endpackage

// File: rtl/mhf_addr_hasher.sv
module mhf_addr_hasher #(
    parameter int          NBYTES = mhf_pkg::ADDR_BYTES,
    parameter logic [31:0] POLY   = mhf_pkg::CRC_POLY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              out_done,
    output mhf_pkg::tbl_idx_t out_idx
);
    import mhf_pkg::*;

    localparam int            CW   = $clog2(NBYTES);
    localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);
    localparam int            IW   = WSEL_W + BSEL_W;

    logic [CW-1:0] pos;
    crc_t          crc;
    crc_t          seed;
    crc_t          crc_nxt;

    always_comb begin
        seed    = (pos == '0) ? '1 : crc;
        crc_nxt = crc_step(seed, in_byte, POLY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= '0;
            crc      <= '1;
            out_done <= 1'b0;
            out_idx  <= '0;
        end else begin
            out_done <= 1'b0;
            if (in_valid) begin
                crc <= crc_nxt;
                if (pos == LAST) begin
                    pos      <= '0;
                    out_done <= 1'b1;
                    out_idx  <= tbl_idx_t'(crc_nxt[IW-1:0]);
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    a_r2_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST);

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

endmodule

// File: rtl/mhf_station_match.sv
module mhf_station_match #(
    parameter int NBYTES = mhf_pkg::ADDR_BYTES,
    localparam int SW    = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_sel,
    input  logic [7:0]    cfg_byte,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    output logic          out_group,
    output logic          out_match
);
    localparam logic [SW-1:0] LAST = SW'(NBYTES - 1);

    logic [NBYTES-1:0][7:0] sta;
    logic [SW-1:0]          pos;
    logic                   run_q;
    logic                   run_nxt;
    logic                   grp_q;
    logic                   grp_nxt;

    always_comb begin
        run_nxt = ((pos == '0) ? 1'b1 : run_q) & (in_byte == sta[pos]);
        grp_nxt = (pos == '0) ? in_byte[0] : grp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sta <= '0;
        end else if (cfg_we && (cfg_sel <= LAST)) begin
            sta[cfg_sel] <= cfg_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= '0;
            run_q     <= 1'b0;
            grp_q     <= 1'b0;
            out_group <= 1'b0;
            out_match <= 1'b0;
        end else if (in_valid) begin
            run_q <= run_nxt;
            grp_q <= grp_nxt;
            if (pos == LAST) begin
                pos       <= '0;
                out_group <= grp_nxt;
                out_match <= run_nxt;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    a_r9_bad_sel_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && (cfg_sel > LAST)) |=> $stable(sta));

    a_r7_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST);

endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
    parameter logic [31:0] POLY   = mhf_pkg::CRC_POLY,
    parameter int          NBYTES = mhf_pkg::ADDR_BYTES
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rebuild,
    input  logic                            wr_en,
    input  logic [mhf_pkg::WSEL_W-1:0]      wr_idx,
    input  logic [mhf_pkg::WORD_W-1:0]      wr_data,
    input  logic                            op_done,
    input  mhf_pkg::tbl_idx_t               op_idx,
    input  logic                            op_set,
    input  logic                            all_multi,
    input  logic [mhf_pkg::WSEL_W-1:0]      rd_idx,
    output logic [mhf_pkg::WORD_W-1:0]      rd_data,
    input  mhf_pkg::tbl_idx_t               look_idx,
    output logic                            look_hit
);
    import mhf_pkg::*;

    typedef logic [TBL_WORDS-1:0][WORD_W-1:0] tbl_t;

    localparam tbl_idx_t BC = bcast_index(POLY, NBYTES);

    function automatic tbl_t init_tbl();
        tbl_t t;
        t = '0;
        t[BC.word][BC.bitsel] = 1'b1;
        return t;
    endfunction

    localparam tbl_t INIT = init_tbl();

    tbl_t tbl;
    tbl_t tbl_nxt;

    always_comb begin
        tbl_nxt = tbl;
        if (wr_en) begin
            tbl_nxt[wr_idx] = wr_data;
        end
        if (op_done) begin
            tbl_nxt[op_idx.word][op_idx.bitsel] = op_set;
        end
        if (rebuild) begin
            tbl_nxt = INIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl <= INIT;
        end else begin
            tbl <= tbl_nxt;
        end
    end

    always_comb begin
        rd_data  = all_multi ? '1 : tbl[rd_idx];
        look_hit = all_multi | tbl[look_idx.word][look_idx.bitsel];
    end

    a_r5_rebuild_one_bit: assert property (@(posedge clk) disable iff (rst)
        rebuild |=> ($countones(tbl) == 1));

    a_r10_rebuild_beats_write: assert property (@(posedge clk) disable iff (rst)
        (rebuild && wr_en) |=> (tbl == INIT));

    a_r4_hash_op_applied: assert property (@(posedge clk) disable iff (rst)
        (op_done && !rebuild) |=>
            (tbl[$past(op_idx.word)][$past(op_idx.bitsel)] == $past(op_set)));

    a_r3_word_written: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rebuild && !(op_done && (op_idx.word == wr_idx))) |=>
            (tbl[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/mhf_addr_filter.sv
module mhf_addr_filter #(
    parameter int          ADDR_BYTES = mhf_pkg::ADDR_BYTES,
    parameter logic [31:0] POLY       = mhf_pkg::CRC_POLY,
    localparam int         SEL_W      = $clog2(ADDR_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       promisc,
    input  logic                       all_multi,
    input  logic                       rebuild,
    input  logic                       tbl_wr_en,
    input  logic [mhf_pkg::WSEL_W-1:0] tbl_wr_idx,
    input  logic [mhf_pkg::WORD_W-1:0] tbl_wr_data,
    input  logic [mhf_pkg::WSEL_W-1:0] tbl_rd_idx,
    output logic [mhf_pkg::WORD_W-1:0] tbl_rd_data,
    input  logic                       sta_wr_en,
    input  logic [SEL_W-1:0]           sta_wr_sel,
    input  logic [7:0]                 sta_wr_byte,
    input  logic                       hp_valid,
    input  logic [7:0]                 hp_byte,
    input  logic                       hp_set,
    input  logic                       da_valid,
    input  logic [7:0]                 da_byte,
    output logic                       dec_valid,
    output logic                       dec_accept
);
    import mhf_pkg::*;

    logic     da_done;
    tbl_idx_t da_idx;
    logic     hp_done;
    tbl_idx_t hp_idx;
    logic     hp_set_q;
    logic     da_group;
    logic     da_match;
    logic     da_hit;

    // frame path hash
    mhf_addr_hasher #(.NBYTES(ADDR_BYTES), .POLY(POLY)) u_da_hash (
        .clk      (clk),
        .rst      (rst),
        .in_valid (da_valid),
        .in_byte  (da_byte),
        .out_done (da_done),
        .out_idx  (da_idx)
    );

    // host path hash
    mhf_addr_hasher #(.NBYTES(ADDR_BYTES), .POLY(POLY)) u_hp_hash (
        .clk      (clk),
        .rst      (rst),
        .in_valid (hp_valid),
        .in_byte  (hp_byte),
        .out_done (hp_done),
        .out_idx  (hp_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hp_set_q <= 1'b0;
        end else if (hp_valid) begin
            hp_set_q <= hp_set;
        end
    end

    mhf_station_match #(.NBYTES(ADDR_BYTES)) u_sta (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (sta_wr_en),
        .cfg_sel   (sta_wr_sel),
        .cfg_byte  (sta_wr_byte),
        .in_valid  (da_valid),
        .in_byte   (da_byte),
        .out_group (da_group),
        .out_match (da_match)
    );

    mhf_hash_table #(.POLY(POLY), .NBYTES(ADDR_BYTES)) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .rebuild   (rebuild),
        .wr_en     (tbl_wr_en),
        .wr_idx    (tbl_wr_idx),
        .wr_data   (tbl_wr_data),
        .op_done   (hp_done),
        .op_idx    (hp_idx),
        .op_set    (hp_set_q),
        .all_multi (all_multi),
        .rd_idx    (tbl_rd_idx),
        .rd_data   (tbl_rd_data),
        .look_idx  (da_idx),
        .look_hit  (da_hit)
    );

    always_comb begin
        dec_valid  = da_done;
        dec_accept = da_done & (promisc | (da_group ? da_hit : da_match));
    end

endmodule

// File: tb/mhf_addr_filter_test.sv
module mhf_addr_filter_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        promisc, all_multi, rebuild;
    logic        tbl_wr_en;
    logic [3:0]  tbl_wr_idx;
    logic [15:0] tbl_wr_data;
    logic [3:0]  tbl_rd_idx;
    logic [15:0] tbl_rd_data;
    logic        sta_wr_en;
    logic [2:0]  sta_wr_sel;
    logic [7:0]  sta_wr_byte;
    logic        hp_valid, hp_set;
    logic [7:0]  hp_byte;
    logic        da_valid;
    logic [7:0]  da_byte;
    logic        dec_valid, dec_accept;

    int total = 0;
    int bad   = 0;

    logic [15:0] exp_tbl [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    mhf_addr_filter uut (
        .clk(clk), .rst(rst), .promisc(promisc), .all_multi(all_multi),
        .rebuild(rebuild), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_data(tbl_wr_data), .tbl_rd_idx(tbl_rd_idx), .tbl_rd_data(tbl_rd_data),
        .sta_wr_en(sta_wr_en), .sta_wr_sel(sta_wr_sel), .sta_wr_byte(sta_wr_byte),
        .hp_valid(hp_valid), .hp_byte(hp_byte), .hp_set(hp_set),
        .da_valid(da_valid), .da_byte(da_byte),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    // bitwise reflected CRC model, returns remainder bits [7:0]
    function automatic logic [7:0] hash_of(input logic [47:0] a);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 8; j++) begin
                fb = c[0] ^ a[47 - 8*i - 7 + j];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return c[7:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_init();
        logic [7:0] b;
        b = hash_of(48'hFFFF_FFFF_FFFF);
        for (int w = 0; w < 16; w++) exp_tbl[w] = 16'h0;
        exp_tbl[b[7:4]][b[3:0]] = 1'b1;
    endtask

    task automatic check_table(input string req);
        int errs;
        errs = 0;
        for (int w = 0; w < 16; w++) begin
            tbl_rd_idx = w[3:0];
            #1;
            if (tbl_rd_data !== exp_tbl[w]) begin
                errs++;
                $display("FAIL %s word %0d actual=%0h expected=%0h", req, w, tbl_rd_data, exp_tbl[w]);
            end
        end
        total++;
        if (errs != 0) bad++;
    endtask

    task automatic write_word(input int w, input logic [15:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = w[3:0]; tbl_wr_data = d;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        exp_tbl[w] = d;
    endtask

    task automatic write_sta(input int sel, input logic [7:0] d);
        @(negedge clk);
        sta_wr_en = 1'b1; sta_wr_sel = sel[2:0]; sta_wr_byte = d;
        @(negedge clk);
        sta_wr_en = 1'b0;
    endtask

    // returns strobe in decision cycle, accept, and strobe one cycle later
    task automatic send_da(input logic [47:0] a, input bit gap,
                           output logic v, output logic acc, output logic v_after);
        for (int i = 0; i < 6; i++) begin
            if (gap && i > 0) begin
                @(negedge clk);
                da_valid = 1'b0;
            end
            @(negedge clk);
            da_valid = 1'b1;
            da_byte  = a[47 - 8*i -: 8];
        end
        @(negedge clk);
        da_valid = 1'b0;
        v   = dec_valid;
        acc = dec_accept;
        @(negedge clk);
        v_after = dec_valid;
    endtask

    task automatic hash_op(input logic [47:0] a, input logic set);
        logic [7:0] h;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            hp_valid = 1'b1;
            hp_byte  = a[47 - 8*i -: 8];
            hp_set   = set;
        end
        @(negedge clk);
        hp_valid = 1'b0;
        hp_set   = ~set;
        @(negedge clk);
        h = hash_of(a);
        exp_tbl[h[7:4]][h[3:0]] = set;
    endtask

    function automatic logic [47:0] rand_addr(input bit group);
        logic [47:0] a;
        a = {$urandom(), $urandom()};
        a[40] = group;
        return a;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic v, acc, va;
        logic [47:0] a;
        logic [47:0] sta_addr;
        logic [7:0]  h;
        logic [15:0] pat [16];

        rst = 1'b1; promisc = 0; all_multi = 0; rebuild = 0;
        tbl_wr_en = 0; tbl_wr_idx = 0; tbl_wr_data = 0; tbl_rd_idx = 0;
        sta_wr_en = 0; sta_wr_sel = 0; sta_wr_byte = 0;
        hp_valid = 0; hp_byte = 0; hp_set = 0; da_valid = 0; da_byte = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state: broadcast bit only (R5), no strobe (R2)
        model_init();
        chk("R2 reset strobe", {31'h0, dec_valid}, 0);
        check_table("R5 reset table");

        // broadcast accepted after reset (R1, R5)
        send_da(48'hFFFF_FFFF_FFFF, 0, v, acc, va);
        chk("R5 broadcast accepted", {31'h0, acc}, 1);
        chk("R2 strobe high", {31'h0, v}, 1);
        chk("R2 strobe one cycle", {31'h0, va}, 0);

        // word writes and read-back (R3)
        for (int w = 0; w < 16; w++) write_word(w, 16'h1111 * w[15:0] ^ 16'hA5C3);
        check_table("R3 word write");

        // rebuild wins over simultaneous write (R10)
        @(negedge clk);
        rebuild = 1'b1; tbl_wr_en = 1'b1; tbl_wr_idx = 4'd7; tbl_wr_data = 16'hBEEF;
        @(negedge clk);
        rebuild = 1'b0; tbl_wr_en = 1'b0;
        model_init();
        check_table("R10 rebuild priority");

        // table lookup sweep with two complementary patterns (R1)
        for (int w = 0; w < 16; w++) pat[w] = {$urandom()} [15:0];
        for (int p = 0; p < 2; p++) begin
            int errs;
            for (int w = 0; w < 16; w++) write_word(w, p == 0 ? pat[w] : ~pat[w]);
            errs = 0;
            for (int n = 0; n < 48; n++) begin
                a = rand_addr(1);
                h = hash_of(a);
                send_da(a, n[0], v, acc, va);
                if (v !== 1'b1 || va !== 1'b0 || acc !== exp_tbl[h[7:4]][h[3:0]]) begin
                    errs++;
                    $display("FAIL R1 addr=%0h actual=%0b/%0b expected=1/%0b",
                             a, v, acc, exp_tbl[h[7:4]][h[3:0]]);
                end
            end
            total++;
            if (errs != 0) bad++;
        end

        // host hash port set then clear (R4)
        @(negedge clk); rebuild = 1'b1; @(negedge clk); rebuild = 1'b0;
        model_init();
        for (int n = 0; n < 24; n++) begin
            a = rand_addr(n[0]);
            hash_op(a, 1'b1);
        end
        check_table("R4 hash set");
        for (int n = 0; n < 24; n++) begin
            a = rand_addr(1);
            hash_op(a, 1'b0);
        end
        hash_op(48'hFFFF_FFFF_FFFF, 1'b0);
        check_table("R4 hash clear");
        hash_op(48'h0180_C200_0001, 1'b1);
        h = hash_of(48'h0180_C200_0001);
        send_da(48'h0180_C200_0001, 0, v, acc, va);
        chk("R4 set bit accepts", {31'h0, acc}, 1);

        // find a group address whose bit is clear
        @(negedge clk); rebuild = 1'b1; @(negedge clk); rebuild = 1'b0;
        model_init();
        a = rand_addr(1);
        h = hash_of(a);
        while (exp_tbl[h[7:4]][h[3:0]] == 1'b1) begin
            a = rand_addr(1);
            h = hash_of(a);
        end
        send_da(a, 0, v, acc, va);
        chk("R1 clear bit drops", {31'h0, acc}, 0);

        // all-multicast (R6)
        all_multi = 1'b1;
        for (int w = 0; w < 16; w++) begin
            tbl_rd_idx = w[3:0];
            #1;
            chk("R6 all-multi read", {16'h0, tbl_rd_data}, 32'hFFFF);
        end
        send_da(a, 0, v, acc, va);
        chk("R6 all-multi group accept", {31'h0, acc}, 1);
        all_multi = 1'b0;
        check_table("R6 table kept");

        // station match (R7)
        sta_addr = 48'h0A1B_2C3D_4E5F;
        for (int s = 0; s < 6; s++) write_sta(s, sta_addr[47 - 8*s -: 8]);
        send_da(sta_addr, 1, v, acc, va);
        chk("R7 station accept", {31'h0, acc}, 1);
        for (int s = 0; s < 6; s++) begin
            logic [47:0] bad_addr;
            bad_addr = sta_addr ^ (48'h1 << (8*(5 - s) + 1));
            send_da(bad_addr, 0, v, acc, va);
            chk($sformatf("R7 byte %0d mismatch drops", s), {31'h0, acc}, 0);
        end

        // select 6 and 7 ignored (R9)
        write_sta(6, 8'h00);
        write_sta(7, 8'hFF);
        send_da(sta_addr, 0, v, acc, va);
        chk("R9 bad select ignored", {31'h0, acc}, 1);

        // promiscuous (R8)
        promisc = 1'b1;
        send_da(48'h0011_2233_4455, 0, v, acc, va);
        chk("R8 promisc unicast", {31'h0, acc}, 1);
        send_da(a, 0, v, acc, va);
        chk("R8 promisc group", {31'h0, acc}, 1);
        promisc = 1'b0;
        send_da(48'h0011_2233_4455, 0, v, acc, va);
        chk("R7 other unicast drops", {31'h0, acc}, 0);
        chk("R2 no accept without strobe", {31'h0, dec_accept}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule